// File: doc/BRIEF.md
# DRAM Auto-Refresh Request Timer

This block tells a DDR-SDRAM controller when an auto-refresh is due. A 13-bit counter advances once per memory-clock cycle. When it reaches the programmed refresh interval, it wraps back to zero and raises a refresh request. The request stays up until the controller reports that a refresh has been carried out. Only one request can be outstanding; further interval expiries while it is pending are absorbed.

Counting happens only while three conditions hold: the controller is enabled, refresh is enabled, and the controller is not in mode-register access. If any of these fails, the counter is held at zero and any pending request is dropped.

The interval value is sampled only while refresh is disabled. Software is expected to clear the refresh enable, present the new interval, and then enable refresh again. An interval below the minimum is not rejected: the minimum is added to it to form the compare value that is used.

Top module: `dram_refresh_timer`

## Requirements
- R1: After synchronous reset, `count_o` is 0 and `req_o` is 0. The interval in use is 0x0C34, which gives the first request 0x0C35 clock cycles after counting starts.
- R2: Counting is allowed while `ctl_en`=1, `ref_en`=1 and `mode_hold`=0. While it is allowed, `count_o` rises by exactly one on each clock until a match occurs.
- R3: If `ctl_en`=0, `ref_en`=0 or `mode_hold`=1 at a clock edge, then after that edge `count_o` is 0 and `req_o` is 0.
- R4: A clock edge at which counting is allowed and `count_o` equals the effective interval is a match. After a match edge, `count_o` is 0 and `req_o` is 1. Requests therefore repeat every effective interval + 1 cycles.
- R5: A sampled interval below 0x020 has 0x020 added to it. For example, 0x005 behaves as 0x025. An interval of 0x020 or more is used unchanged.
- R6: At most one request is outstanding. After several matches with no done strobe, a single `done_i` pulse clears `req_o`, and it stays 0 until the next match.
- R7: While counting is allowed, `req_o` holds at 1 until a clock edge with `done_i`=1 and no match. After that edge, `req_o` is 0.
- R8: If `done_i`=1 arrives on a match edge, `req_o` stays 1 after that edge.
- R9: `interval_i` is sampled at every clock edge where `ref_en`=0. Changes made to it while `ref_en`=1 have no effect on request timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Controller enable |
| ref_en | input | 1 | Refresh enable; interval is sampled while 0 |
| mode_hold | input | 1 | Mode-register access in progress; holds the timer clear |
| interval_i | input | 13 | Requested refresh interval in clock cycles |
| done_i | input | 1 | One-cycle strobe: a refresh has been performed |
| req_o | output | 1 | Pending auto-refresh request |
| count_o | output | 13 | Current counter value |

## Verification
The assertions assume that `interval_i` matters only while `ref_en` is low. This is why the stability check on the effective interval is conditioned on `ref_en`. They also assume `done_i` is meaningful only while a request can be pending.

The stimulus respects the programming rule. It changes the interval only in cycles where refresh is disabled, keeps random intervals small so that matches happen often, and pulses the done strobe at random, sometimes on a match edge. Directed passes also move `interval_i` while refresh is enabled, to show that the change is ignored.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;
  localparam int unsigned RT_CNT_W  = 13;
  localparam int unsigned RT_MIN_IV = 32'h020;
  localparam int unsigned RT_RST_IV = 32'h0C34;
endpackage

// File: rtl/rft_interval_reg.sv
module rft_interval_reg #(
  parameter int unsigned CNT_W  = dram_refresh_pkg::RT_CNT_W,
  parameter int unsigned MIN_IV = dram_refresh_pkg::RT_MIN_IV,
  parameter int unsigned RST_IV = dram_refresh_pkg::RT_RST_IV
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_en,
  input  logic [CNT_W-1:0] interval_i,
  output logic [CNT_W-1:0] eff_o
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_IV);
  localparam logic [CNT_W-1:0] RST_V = CNT_W'(RST_IV);

  function automatic logic [CNT_W-1:0] clamp(input logic [CNT_W-1:0] v);
    return (v < MIN_V) ? (v + MIN_V) : v;
  endfunction

  logic [CNT_W-1:0] eff_q;

  always_ff @(posedge clk) begin
    if (rst)          eff_q <= clamp(RST_V);
    else if (!ref_en) eff_q <= clamp(interval_i);
  end

  assign eff_o = eff_q;

  assert_eff_floor_R5: assert property (@(posedge clk) disable iff (rst)
    eff_q >= MIN_V);
  assert_eff_stable_R9: assert property (@(posedge clk) disable iff (rst)
    ref_en |=> $stable(eff_q));
endmodule

// File: rtl/rft_counter.sv
module rft_counter #(
  parameter int unsigned CNT_W = dram_refresh_pkg::RT_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] eff_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q;

  assign match_o = run && (cnt_q == eff_i);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt_q <= '0;
    else if (match_o) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_clear_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));
  assert_wrap_on_match_R4: assert property (@(posedge clk) disable iff (rst)
    match_o |=> (cnt_q == '0));
  assert_step_one_R2: assert property (@(posedge clk) disable iff (rst)
    (run && !match_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= eff_i);
endmodule

// File: rtl/rft_req_latch.sv
module rft_req_latch (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic match_i,
  input  logic done_i,
  output logic req_o
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (rst || !run)  req_q <= 1'b0;
    else if (match_i) req_q <= 1'b1;
    else if (done_i)  req_q <= 1'b0;
  end

  assign req_o = req_q;

  assert_req_set_R4: assert property (@(posedge clk) disable iff (rst)
    match_i |=> req_q);
  assert_req_drop_R3: assert property (@(posedge clk) disable iff (rst)
    !run |=> !req_q);
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (run && req_q && !done_i) |=> req_q);
  assert_done_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (run && !match_i && done_i) |=> !req_q);
  assert_match_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (match_i && done_i) |=> req_q);
endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int unsigned CNT_W  = dram_refresh_pkg::RT_CNT_W,
  parameter int unsigned MIN_IV = dram_refresh_pkg::RT_MIN_IV,
  parameter int unsigned RST_IV = dram_refresh_pkg::RT_RST_IV
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_en,
  input  logic             ref_en,
  input  logic             mode_hold,
  input  logic [CNT_W-1:0] interval_i,
  input  logic             done_i,
  output logic             req_o,
  output logic [CNT_W-1:0] count_o
);
  logic             run;
  logic             match;
  logic [CNT_W-1:0] eff;

  assign run = ctl_en && ref_en && !mode_hold;

  rft_interval_reg #(.CNT_W(CNT_W), .MIN_IV(MIN_IV), .RST_IV(RST_IV)) u_iv (
    .clk(clk), .rst(rst), .ref_en(ref_en), .interval_i(interval_i), .eff_o(eff));

  rft_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .eff_i(eff), .cnt_o(count_o), .match_o(match));

  rft_req_latch u_req (
    .clk(clk), .rst(rst), .run(run), .match_i(match), .done_i(done_i), .req_o(req_o));
endmodule

// File: tb/dram_refresh_timer_test.sv
module dram_refresh_timer_test;
  localparam int W = 13;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_en = 1'b1, ref_en = 1'b1, mode_hold = 1'b0, done_i = 1'b0;
  logic [W-1:0] interval_i = 13'h100;
  logic req_o;
  logic [W-1:0] count_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dram_refresh_timer uut (.clk(clk), .rst(rst), .ctl_en(ctl_en), .ref_en(ref_en),
    .mode_hold(mode_hold), .interval_i(interval_i), .done_i(done_i),
    .req_o(req_o), .count_o(count_o));

  function automatic logic [W-1:0] eff_of(input logic [W-1:0] v);
    return (v < 13'h020) ? v + 13'h020 : v;
  endfunction

  logic [W-1:0] m_cnt, m_eff;
  logic m_req;
  logic m_run;
  assign m_run = ctl_en && ref_en && !mode_hold;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= '0; m_req <= 1'b0; m_eff <= eff_of(13'h0C34);
    end else begin
      if (!ref_en) m_eff <= eff_of(interval_i);
      if (!m_run) begin
        m_cnt <= '0; m_req <= 1'b0;
      end else if (m_cnt == m_eff) begin
        m_cnt <= '0; m_req <= 1'b1;
      end else begin
        m_cnt <= m_cnt + 1'b1;
        if (done_i) m_req <= 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk("R2 count vs model", int'(count_o), int'(m_cnt));
    chk("R7 req vs model", int'(req_o), int'(m_req));
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset count", int'(count_o), 0);
    chk("R1 reset req", int'(req_o), 0);
    // default interval 0x0C34; interval_i=0x100 is ignored while enabled (R9)
    steps(13'h0C34);
    chk("R1 count before first match", int'(count_o), 13'h0C34);
    chk("R9 no early request", int'(req_o), 0);
    step();
    chk("R4 count wraps", int'(count_o), 0);
    chk("R4 request raised", int'(req_o), 1);
    // second match without done: still one request (R6)
    steps(13'h0C35);
    chk("R6 still pending", int'(req_o), 1);
    done_i = 1'b1; step(); done_i = 1'b0;
    chk("R6 single done clears", int'(req_o), 0);
    step();
    chk("R6 stays clear", int'(req_o), 0);
    // program small interval 0x005 -> effective 0x025 (R5)
    ref_en = 1'b0; interval_i = 13'h005; step();
    chk("R3 ref_en low clears count", int'(count_o), 0);
    ref_en = 1'b1; interval_i = 13'h7FF;
    steps(13'h025);
    chk("R5 count reaches clamped value", int'(count_o), 13'h025);
    chk("R5 no request yet", int'(req_o), 0);
    step();
    chk("R5 request at clamped interval", int'(req_o), 1);
    steps(13'h025);
    done_i = 1'b1; step(); done_i = 1'b0;
    chk("R8 done on match keeps request", int'(req_o), 1);
    chk("R8 count wrapped", int'(count_o), 0);
    steps(5);
    done_i = 1'b1; step(); done_i = 1'b0;
    chk("R7 done clears request", int'(req_o), 0);
    steps(13'h025 - 5);
    step();
    mode_hold = 1'b1; step(); mode_hold = 1'b0;
    chk("R3 mode flag clears count", int'(count_o), 0);
    chk("R3 mode flag drops request", int'(req_o), 0);
    steps(13'h026);
    ctl_en = 1'b0; step(); ctl_en = 1'b1;
    chk("R3 ctl_en low drops request", int'(req_o), 0);
    // constrained random phase
    for (int c = 0; c < 20000; c++) begin
      if ($urandom_range(0, 199) == 0) begin
        ref_en = 1'b0; interval_i = W'($urandom_range(0, 13'h60));
        steps($urandom_range(1, 3));
        ref_en = 1'b1;
      end
      mode_hold = ($urandom_range(0, 299) == 0);
      ctl_en    = ($urandom_range(0, 399) != 0);
      done_i    = ($urandom_range(0, 7) == 0);
      step();
    end
    done_i = 1'b0; mode_hold = 1'b0; ctl_en = 1'b1;
    finish_run();
  end
endmodule